// File: doc/BRIEF.md
# SPI Target Controller with Register Bank

This block lets a remote SPI controller exchange bytes with on-chip software. Software programs a configuration register, pushes 32-bit words of outgoing data into a transmit queue and pops 32-bit words of incoming data from a receive queue. The serial side is a target. It never drives the clock; it follows the controller's chip select and clock.

The three serial inputs are resampled in the system clock domain through short synchronizer chains. Edges of the resampled clock then drive a bit engine that supports all four clock polarity and phase combinations. Each direction has its own enable, bit order and byte-lane swap. Incoming bytes are packed into words, lowest lane first. Outgoing words are unpacked the same way. A four-source interrupt block has separate enable, mask, status and write-one-to-clear registers, and drives a level interrupt line.

A soft reset empties both queues and returns the engine to idle. Configuration is kept. The address and DMA-setup registers are plain storage for a separate data mover.

Top module: `spi_tgt_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq_o` is low and `spi_miso_o` is low.
- R2: A word written at 0x18 joins the transmit queue. Its bytes go out lane 0 (bits 7:0) first. Configuration bit 5 set sends bit 7 of each byte first; clear sends bit 0 first.
- R3: Received bytes are packed lane 0 first into words read at 0x14. Configuration bit 4 selects the received bit order the same way. A partly filled word is queued when chip select rises, with its unused lanes zero. A read at 0x14 with an empty queue returns 0.
- R4: Configuration bit 2 is the clock idle level and bit 3 the phase. With phase 0 the target samples on the edge leaving idle. With phase 1 it samples on the edge returning to idle. All four modes work.
- R5: With configuration bit 1 clear, `spi_miso_o` stays 0 and the transmit queue is not consumed.
- R6: With configuration bit 0 clear, received bytes are not stored.
- R7: If no transmit data is queued when a byte starts, the target sends 0x00.
- R8: A received word that finds the receive queue full is dropped, and status bit 0 is set.
- R9: When chip select rises after at least one whole byte, status bit 2 is set if reception is enabled and status bit 1 is set if transmission is enabled.
- R10: Writing at 0x04 clears each status bit (at 0x08) that is 1 in the written value.
- R11: `irq_o` is high exactly when some status bit has its enable bit (0x00) and its mask bit (0x0C) both at 1. Interrupt bits are 7, 2, 1 and 0 in all four registers.
- R12: Writing 1 to bit 0 at 0x40 empties both queues and idles the engine while configuration is kept. Bit 1 at 0x40 is stored and read back.
- R13: Configuration bit 7 reverses byte lanes of words written at 0x18. Bit 6 reverses byte lanes of words read at 0x14.
- R14: 0x1C and 0x20 read back all 32 written bits. 0x30 reads back written bits 31:29 and 19:0, and reads 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (pops the receive queue at 0x14) |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while the address is applied |
| spi_sck_i | input | 1 | Serial clock from the controller |
| spi_mosi_i | input | 1 | Serial data into the target |
| spi_cs_n_i | input | 1 | Active-low chip select |
| spi_miso_o | output | 1 | Serial data out of the target |
| irq_o | output | 1 | Level interrupt |

## Verification
Internal state shows up at the ports in three places. A wrong bit counter or lane counter puts bytes out of place on `spi_miso_o` within the same byte. A wrong receive lane or a lost flush puts wrong words at 0x14 as soon as the transfer ends. A wrong status update or a queue that is not emptied shows in the 0x08 readback or on `irq_o` a few cycles after chip select rises or after the soft reset. The directed scenarios therefore check every transmitted byte, read every received word, and read the status after each transfer.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned LANES  = DATA_W / 8;

    localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ICLR   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ISTAT  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_IMSK   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_RXD    = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_TXD    = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_RXADDR = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_TXADDR = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_XCFG   = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_SRST   = 8'h40;

    localparam logic [DATA_W-1:0] XCFG_KEEP = 32'hE00F_FFFF;

    // field order equals register bit order (bit 7 .. bit 0)
    typedef struct packed {
        logic tx_swap;
        logic rx_swap;
        logic tx_msb;
        logic rx_msb;
        logic cpha;
        logic cpol;
        logic tx_en;
        logic rx_en;
    } cfg_t;

    // compact event vector: [3] mover done, [2] rx done, [1] tx done, [0] bad
    typedef logic [3:0] evt_t;

    function automatic logic [DATA_W-1:0] evt_spread(evt_t e);
        return {24'b0, e[3], 4'b0, e[2:0]};
    endfunction

    function automatic evt_t evt_gather(logic [DATA_W-1:0] w);
        return {w[7], w[2:0]};
    endfunction

    function automatic logic [DATA_W-1:0] lane_rev(logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            r[8*i +: 8] = w[8*(LANES-1-i) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_tgt_fifo.sv
module spi_tgt_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush_i,
    input  logic         push_i,
    input  logic [W-1:0] wdata_i,
    input  logic         pop_i,
    output logic [W-1:0] rdata_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full_o  = (count == CW'(DEPTH));
    assign empty_o = (count == '0);
    assign rdata_o = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_i && !full_o) mem[wr_ptr] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_i && !full_o) wr_ptr <= bump(wr_ptr);
            if (pop_i && !empty_o) rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push_i && !full_o) - CW'(pop_i && !empty_o);
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        full_o |-> !push_i);

    // R3
    fill_step_chk: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && !flush_i) |=> (count == $past(count) + CW'(1)));
endmodule

// File: rtl/spi_tgt_engine.sv
module spi_tgt_engine
    import spi_tgt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              srst_i,
    input  cfg_t              cfg_i,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              cs_n_i,
    output logic              miso_o,
    input  logic [DATA_W-1:0] tx_word_i,
    input  logic              tx_empty_i,
    output logic              tx_pop_o,
    input  logic              rx_full_i,
    output logic              rx_push_o,
    output logic [DATA_W-1:0] rx_word_o,
    output evt_t              ev_o
);
    localparam int unsigned LW = $clog2(LANES);

    logic cs_s, sck_s, mosi_s;

    spi_tgt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({cs_n_i, sck_i, mosi_i}),
        .q_o ({cs_s, sck_s, mosi_s})
    );

    logic              sck_d, cs_d;
    logic [2:0]        rx_cnt;
    logic [7:0]        rx_sh;
    logic [LW-1:0]     rx_lane;
    logic [DATA_W-1:0] rx_pack;
    logic [7:0]        tx_byte;
    logic [2:0]        tx_idx;
    logic [LW-1:0]     tx_lane;
    logic              tx_live;
    logic              seen;

    logic cs_fall, cs_rise, sck_rise, sck_fall, lead, trail, smp, shf;
    logic from_q;
    logic [7:0] peek, rx_next;
    logic [DATA_W-1:0] rx_merge;

    assign cs_fall  = cs_d & ~cs_s;
    assign cs_rise  = ~cs_d & cs_s;
    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign lead     = cfg_i.cpol ? sck_fall : sck_rise;
    assign trail    = cfg_i.cpol ? sck_rise : sck_fall;
    assign smp      = ~cs_s & (cfg_i.cpha ? trail : lead);
    assign shf      = ~cs_s & (cfg_i.cpha ? lead : trail);

    assign from_q   = cfg_i.tx_en & ~tx_empty_i;
    assign peek     = from_q ? tx_word_i[{tx_lane, 3'b000} +: 8] : 8'h00;
    assign rx_next  = cfg_i.rx_msb ? {rx_sh[6:0], mosi_s} : {mosi_s, rx_sh[7:1]};
    assign rx_merge = rx_pack | (DATA_W'(rx_next) << {rx_lane, 3'b000});

    always_ff @(posedge clk) begin
        if (rst || srst_i) begin
            sck_d     <= 1'b0;
            cs_d      <= 1'b1;
            rx_cnt    <= '0;
            rx_sh     <= '0;
            rx_lane   <= '0;
            rx_pack   <= '0;
            tx_byte   <= '0;
            tx_idx    <= '0;
            tx_lane   <= '0;
            tx_live   <= 1'b0;
            seen      <= 1'b0;
            miso_o    <= 1'b0;
            tx_pop_o  <= 1'b0;
            rx_push_o <= 1'b0;
            rx_word_o <= '0;
            ev_o      <= '0;
        end else begin
            sck_d     <= sck_s;
            cs_d      <= cs_s;
            tx_pop_o  <= 1'b0;
            rx_push_o <= 1'b0;
            ev_o      <= '0;
            miso_o    <= cfg_i.tx_en & tx_byte[cfg_i.tx_msb ? 3'd7 - tx_idx : tx_idx];

            if (cs_fall) begin
                rx_cnt <= '0;
                rx_sh  <= '0;
                seen   <= 1'b0;
                if (cfg_i.cpha) begin
                    tx_idx  <= 3'd7;
                    tx_live <= 1'b0;
                end else begin
                    tx_byte <= peek;
                    tx_live <= from_q;
                    tx_idx  <= '0;
                end
            end

            if (cs_rise) begin
                rx_cnt <= '0;
                if (rx_lane != '0) begin
                    if (rx_full_i) begin
                        ev_o[0] <= 1'b1;
                    end else begin
                        rx_push_o <= 1'b1;
                        rx_word_o <= rx_pack;
                    end
                end
                rx_lane <= '0;
                rx_pack <= '0;
                ev_o[2] <= seen & cfg_i.rx_en;
                ev_o[1] <= seen & cfg_i.tx_en;
                seen    <= 1'b0;
            end

            if (smp) begin
                rx_sh  <= rx_next;
                rx_cnt <= rx_cnt + 3'd1;
                if (rx_cnt == 3'd0 && tx_live) begin
                    tx_live <= 1'b0;
                    tx_lane <= tx_lane + LW'(1);
                    if (tx_lane == LW'(LANES - 1)) tx_pop_o <= 1'b1;
                end
                if (rx_cnt == 3'd7) begin
                    seen <= 1'b1;
                    if (cfg_i.rx_en) begin
                        rx_lane <= rx_lane + LW'(1);
                        if (rx_lane == LW'(LANES - 1)) begin
                            rx_pack <= '0;
                            if (rx_full_i) begin
                                ev_o[0] <= 1'b1;
                            end else begin
                                rx_push_o <= 1'b1;
                                rx_word_o <= rx_merge;
                            end
                        end else begin
                            rx_pack <= rx_merge;
                        end
                    end
                end
            end

            if (shf) begin
                if (tx_idx == 3'd7) begin
                    tx_byte <= peek;
                    tx_live <= from_q;
                    tx_idx  <= '0;
                end else begin
                    tx_idx <= tx_idx + 3'd1;
                end
            end
        end
    end

    // R5
    tx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_i.tx_en |=> !miso_o);

    // R7
    pop_src_chk: assert property (@(posedge clk) disable iff (rst)
        tx_pop_o |-> !tx_empty_i);
endmodule

// File: rtl/spi_tgt_ctrl.sv
module spi_tgt_ctrl
    import spi_tgt_pkg::*;
#(
    parameter int unsigned FIFO_BYTES  = 128,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              spi_sck_i,
    input  logic              spi_mosi_i,
    input  logic              spi_cs_n_i,
    output logic              spi_miso_o,
    output logic              irq_o
);
    localparam int unsigned WORDS = FIFO_BYTES / LANES;

    cfg_t              cfg;
    evt_t              ien, imsk, stat, clr, ev;
    logic [DATA_W-1:0] rx_addr, tx_addr, xcfg;
    logic              addr_keep;

    logic              srst, tx_push, tx_pop, tx_full, tx_empty;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [DATA_W-1:0] tx_head, rx_head, rx_word, tx_in;

    assign srst    = bus_wr_i && bus_addr_i == OFS_SRST && bus_wdata_i[0];
    assign clr     = (bus_wr_i && bus_addr_i == OFS_ICLR) ? evt_gather(bus_wdata_i) : '0;
    assign tx_push = bus_wr_i && bus_addr_i == OFS_TXD && !tx_full;
    assign tx_in   = cfg.tx_swap ? lane_rev(bus_wdata_i) : bus_wdata_i;
    assign rx_pop  = bus_rd_i && bus_addr_i == OFS_RXD && !rx_empty;
    assign irq_o   = |(stat & ien & imsk);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            ien       <= '0;
            imsk      <= '0;
            stat      <= '0;
            rx_addr   <= '0;
            tx_addr   <= '0;
            xcfg      <= '0;
            addr_keep <= 1'b0;
        end else begin
            stat <= (stat & ~clr) | ev;
            if (bus_wr_i) begin
                case (bus_addr_i)
                    OFS_IEN:    ien       <= evt_gather(bus_wdata_i);
                    OFS_IMSK:   imsk      <= evt_gather(bus_wdata_i);
                    OFS_CFG:    cfg       <= cfg_t'(bus_wdata_i[7:0]);
                    OFS_RXADDR: rx_addr   <= bus_wdata_i;
                    OFS_TXADDR: tx_addr   <= bus_wdata_i;
                    OFS_XCFG:   xcfg      <= bus_wdata_i & XCFG_KEEP;
                    OFS_SRST:   addr_keep <= bus_wdata_i[1];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (bus_addr_i)
            OFS_IEN:    bus_rdata_o = evt_spread(ien);
            OFS_ISTAT:  bus_rdata_o = evt_spread(stat);
            OFS_IMSK:   bus_rdata_o = evt_spread(imsk);
            OFS_CFG:    bus_rdata_o = {24'b0, cfg};
            OFS_RXD:    bus_rdata_o = rx_empty ? '0 :
                                      (cfg.rx_swap ? lane_rev(rx_head) : rx_head);
            OFS_RXADDR: bus_rdata_o = rx_addr;
            OFS_TXADDR: bus_rdata_o = tx_addr;
            OFS_XCFG:   bus_rdata_o = xcfg;
            OFS_SRST:   bus_rdata_o = {30'b0, addr_keep, 1'b0};
            default:    bus_rdata_o = '0;
        endcase
    end

    spi_tgt_fifo #(.W(DATA_W), .DEPTH(WORDS)) u_txq (
        .clk     (clk),
        .rst     (rst),
        .flush_i (srst),
        .push_i  (tx_push),
        .wdata_i (tx_in),
        .pop_i   (tx_pop),
        .rdata_o (tx_head),
        .full_o  (tx_full),
        .empty_o (tx_empty)
    );

    spi_tgt_fifo #(.W(DATA_W), .DEPTH(WORDS)) u_rxq (
        .clk     (clk),
        .rst     (rst),
        .flush_i (srst),
        .push_i  (rx_push),
        .wdata_i (rx_word),
        .pop_i   (rx_pop),
        .rdata_o (rx_head),
        .full_o  (rx_full),
        .empty_o (rx_empty)
    );

    spi_tgt_engine #(.SYNC_STAGES(SYNC_STAGES)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .srst_i     (srst),
        .cfg_i      (cfg),
        .sck_i      (spi_sck_i),
        .mosi_i     (spi_mosi_i),
        .cs_n_i     (spi_cs_n_i),
        .miso_o     (spi_miso_o),
        .tx_word_i  (tx_head),
        .tx_empty_i (tx_empty),
        .tx_pop_o   (tx_pop),
        .rx_full_i  (rx_full),
        .rx_push_o  (rx_push),
        .rx_word_o  (rx_word),
        .ev_o       (ev)
    );

    // R11
    irq_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |-> !irq_o);

    // R12
    srst_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        srst |=> $stable(cfg));
endmodule

// File: tb/spi_tgt_ctrl_tb.sv
module spi_tgt_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int FIFO_BYTES = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic        miso, irq;

    logic m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_tgt_ctrl #(.FIFO_BYTES(FIFO_BYTES)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .bus_wr_i    (bus_wr),
        .bus_rd_i    (bus_rd),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .spi_sck_i   (sck),
        .spi_mosi_i  (mosi),
        .spi_cs_n_i  (cs_n),
        .spi_miso_o  (miso),
        .irq_o       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_mode(input logic pol, input logic pha, input logic lsb);
        m_cpol = pol; m_cpha = pha; m_lsb = lsb;
        sck = pol;
        wait_clk(4);
    endtask

    task automatic cs_on();
        sck = m_cpol;
        wait_clk(HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_off();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2*HALF);
    endtask

    task automatic xbyte(input logic [7:0] d, output logic [7:0] q);
        for (int i = 0; i < 8; i++) begin
            int b;
            b = m_lsb ? i : 7 - i;
            if (!m_cpha) begin
                mosi = d[b];
                wait_clk(HALF);
                q[b] = miso;
                sck = ~m_cpol;
                wait_clk(HALF);
                sck = m_cpol;
            end else begin
                sck = ~m_cpol;
                mosi = d[b];
                wait_clk(HALF);
                q[b] = miso;
                sck = m_cpol;
                wait_clk(HALF);
            end
        end
    endtask

    task automatic soft_reset();
        reg_wr(8'h40, 32'h1);
        reg_wr(8'h04, 32'h87);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_rd(8'h10, v); chk("R1 cfg", v, 0);
        reg_rd(8'h08, v); chk("R1 status", v, 0);
        reg_rd(8'h00, v); chk("R1 enable", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 miso", {31'b0, miso}, 0);
    endtask

    task automatic t_storage();
        logic [31:0] v;
        reg_wr(8'h1C, 32'hDEADBEEF); reg_rd(8'h1C, v); chk("R14 rx addr", v, 32'hDEADBEEF);
        reg_wr(8'h20, 32'h0BADF00D); reg_rd(8'h20, v); chk("R14 tx addr", v, 32'h0BADF00D);
        reg_wr(8'h30, 32'hFFFFFFFF); reg_rd(8'h30, v); chk("R14 mover cfg", v, 32'hE00FFFFF);
    endtask

    task automatic t_mode0_word();
        logic [7:0]  q;
        logic [31:0] v;
        logic [7:0]  tx_b [4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
        logic [7:0]  ex_b [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        set_mode(0, 0, 0);
        reg_wr(8'h10, 32'h33);
        reg_wr(8'h18, 32'h44332211);
        cs_on();
        for (int k = 0; k < 4; k++) begin
            xbyte(tx_b[k], q);
            chk("R2 tx byte lane order", {24'b0, q}, {24'b0, ex_b[k]});
        end
        cs_off();
        reg_rd(8'h14, v); chk("R3 rx word packing", v, 32'hD4C3B2A1);
        reg_rd(8'h08, v); chk("R9 done status", v, 32'h6);
    endtask

    task automatic t_irq_clear();
        logic [31:0] v;
        reg_wr(8'h00, 32'h04);
        reg_wr(8'h0C, 32'h00);
        wait_clk(1); chk("R11 masked irq", {31'b0, irq}, 0);
        reg_wr(8'h0C, 32'h84);
        wait_clk(1); chk("R11 irq raised", {31'b0, irq}, 1);
        reg_wr(8'h04, 32'h04);
        wait_clk(1); chk("R11 irq after clear", {31'b0, irq}, 0);
        reg_rd(8'h08, v); chk("R10 partial clear", v, 32'h2);
        reg_wr(8'h04, 32'h02);
        reg_rd(8'h08, v); chk("R10 full clear", v, 32'h0);
    endtask

    task automatic t_modes();
        logic [7:0]  q;
        logic [31:0] v;
        for (int m = 1; m < 4; m++) begin
            logic pol, pha;
            pol = m[1]; pha = m[0];
            set_mode(pol, pha, 1);
            reg_wr(8'h10, {28'b0, pha, pol, 2'b11});
            soft_reset();
            reg_wr(8'h18, 32'h12345678);
            cs_on();
            xbyte(8'h5A, q); chk("R4 mode tx byte0 lsb first", {24'b0, q}, 32'h78);
            xbyte(8'hC3, q); chk("R4 mode tx byte1 lsb first", {24'b0, q}, 32'h56);
            cs_off();
            reg_rd(8'h14, v); chk("R3 partial word flush", v, 32'h0000C35A);
        end
        set_mode(0, 0, 0);
    endtask

    task automatic t_tx_off();
        logic [7:0] q;
        reg_wr(8'h10, 32'h31);
        soft_reset();
        reg_wr(8'h18, 32'hFFFFFFFF);
        cs_on(); xbyte(8'h00, q); cs_off();
        chk("R5 tx disabled drives zero", {24'b0, q}, 0);
        reg_wr(8'h10, 32'h33);
        cs_on(); xbyte(8'h00, q); cs_off();
        chk("R5 tx queue untouched", {24'b0, q}, 32'hFF);
    endtask

    task automatic t_rx_off();
        logic [7:0]  q;
        logic [31:0] v;
        reg_wr(8'h10, 32'h32);
        soft_reset();
        cs_on();
        for (int k = 0; k < 4; k++) xbyte(8'h77, q);
        cs_off();
        reg_wr(8'h10, 32'h33);
        reg_rd(8'h14, v); chk("R6 rx disabled stores nothing", v, 0);
        reg_rd(8'h08, v); chk("R9 tx-only status", v, 32'h2);
    endtask

    task automatic t_tx_empty();
        logic [7:0] q;
        soft_reset();
        cs_on(); xbyte(8'h3C, q); cs_off();
        chk("R7 empty queue sends zero", {24'b0, q}, 0);
    endtask

    task automatic t_overflow();
        logic [7:0]  q;
        logic [31:0] v;
        reg_wr(8'h10, 32'h31);
        soft_reset();
        cs_on();
        for (int k = 0; k < FIFO_BYTES + 4; k++) xbyte(8'(k), q);
        cs_off();
        reg_rd(8'h08, v); chk("R8 overflow status", v & 32'h1, 32'h1);
        reg_rd(8'h14, v); chk("R8 first word kept", v, 32'h03020100);
        for (int k = 1; k < FIFO_BYTES/4 - 1; k++) reg_rd(8'h14, v);
        reg_rd(8'h14, v); chk("R8 last stored word", v, 32'h7F7E7D7C);
        reg_rd(8'h14, v); chk("R8 overflow word dropped", v, 0);
    endtask

    task automatic t_swap();
        logic [7:0]  q;
        logic [31:0] v;
        reg_wr(8'h10, 32'hF3);
        soft_reset();
        reg_wr(8'h18, 32'h44332211);
        cs_on();
        xbyte(8'hA1, q); chk("R13 tx lane swap", {24'b0, q}, 32'h44);
        xbyte(8'hB2, q); xbyte(8'hC3, q); xbyte(8'hD4, q);
        cs_off();
        reg_rd(8'h14, v); chk("R13 rx lane swap", v, 32'hA1B2C3D4);
    endtask

    task automatic t_soft_reset();
        logic [7:0]  q;
        logic [31:0] v;
        reg_wr(8'h10, 32'h33);
        soft_reset();
        reg_wr(8'h18, 32'h01020304);
        reg_wr(8'h18, 32'h05060708);
        cs_on();
        for (int k = 0; k < 4; k++) xbyte(8'h99, q);
        cs_off();
        reg_wr(8'h40, 32'h3);
        reg_rd(8'h10, v); chk("R12 cfg kept", v, 32'h33);
        reg_rd(8'h40, v); chk("R12 stored bit", v, 32'h2);
        reg_rd(8'h14, v); chk("R12 rx queue emptied", v, 0);
        cs_on(); xbyte(8'h00, q); cs_off();
        chk("R12 tx queue emptied", {24'b0, q}, 0);
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        t_reset();
        t_storage();
        t_mode0_word();
        t_irq_clear();
        t_modes();
        t_tx_off();
        t_rx_off();
        t_tx_empty();
        t_overflow();
        t_swap();
        t_soft_reset();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all R): actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule